// File: doc/BRIEF.md
# Programmable Waveform Pattern Generator

This block drives a 32-bit parallel output word that changes only on update ticks. An update tick comes either from an internal divider on the system clock or from an external tick pulse. A 3-bit shape code picks what the word does on each tick. In one mode it replays words that were pushed into a small internal buffer. In the other modes it computes the next word from a start value, a stop value, a step size and a hold count. Those computed shapes are a rising ramp, a falling ramp, a pyramid, an inverted pyramid, a square wave, a trapezoid and a one-bit left shift. A run begins on a start pulse or, optionally, on an external trigger. It produces the programmed number of complete shape cycles, or runs without end when that number is zero.

The step size does not have to divide the span between start and stop evenly. A clip bit decides what happens at the final step. With clip set, the last step lands exactly on the limit. With clip clear, the last step passes the limit, so the output overshoots or undershoots.

The playback buffer has a valid/ready push port. `push_ready` is low while a run is active or while the buffer holds `DEPTH` words. A word is taken only on a clock edge where both `push_valid` and `push_ready` are high. A producer that sees `push_ready` low must hold its word and retry. All `cfg_*` inputs must stay stable while `busy` is high.

Top module: `pattern_gen`

## Requirements
- R1: While reset is held and right after it is released, `pat_out` is zero, `busy` and `done` are low, and `push_ready` is high.
- R2: With internal timing (`cfg_tick_ext`=0), the first update happens `cfg_div`+1 clocks after the start edge, and later updates follow every `cfg_div`+1 clocks. Between updates `pat_out` does not change. With `cfg_tick_ext`=1, each clock on which `ext_tick` is high is one update.
- R3: `push_ready` is low while `busy` is high or while the buffer holds `DEPTH` words. A word is stored only on an edge where `push_valid` and `push_ready` are both high. `fifo_clear` empties the buffer while the block is idle.
- R4: Shape code 0 is buffer playback. `pat_out` shows the stored words in push order, starting with the first word at the start edge. After the last word it goes back to the first word, which completes one cycle, and no word is removed. A start with an empty buffer in code 0 is ignored.
- R5: Code 1 (rising ramp) begins at start and adds the step on each update. An update made while the value is at or above stop completes a cycle and reloads start. Code 2 (falling ramp) does the same downward, from start toward a lower stop.
- R6: With `cfg_clip`=1, a step that would reach or cross the limit gives exactly the limit. With `cfg_clip`=0, the output takes the full step past the limit.
- R7: Code 3 (pyramid) rises from start to stop and then falls back, and the update that leaves the bottom completes a cycle. Code 4 (inverted pyramid) falls from start to a lower stop and then rises back, and the update that leaves the top completes a cycle.
- R8: Code 6 (trapezoid) rises like a pyramid. Once the top is reached, it holds the top value for `cfg_hold` more updates, then falls, and the cycle completes when it leaves the bottom.
- R9: Code 5 (square) alternates all 32 bits between start and stop on each update. The update that returns the output to start completes a cycle.
- R10: Code 7 (shift) begins at start and shifts left by one bit on each update. An update made while the value equals stop or zero reloads start and completes a cycle.
- R11: With `cfg_cycles`=N>0, the update that would complete cycle N drops `busy`, sets `done`, and leaves `pat_out` at its last value until the next start. With N=0, the run continues until it is stopped.
- R12: A `stop` pulse during a run drops `busy` at the next edge, leaves `done` low, and freezes `pat_out`. With `cfg_trig_ext`=1, an `ext_trig` pulse starts a run just as `start` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_type | input | 3 | Shape code 0..7 |
| cfg_start | input | W | Start value |
| cfg_stop | input | W | Stop value |
| cfg_slope | input | W | Step size per update |
| cfg_hold | input | CNTW | Extra updates held at the trapezoid top |
| cfg_cycles | input | CNTW | Number of cycles to produce, 0 for endless |
| cfg_div | input | DIVW | Internal update period minus one, in clocks |
| cfg_clip | input | 1 | 1 clips the last step at the limit, 0 lets it overshoot |
| cfg_tick_ext | input | 1 | Take updates from `ext_tick` |
| cfg_trig_ext | input | 1 | Allow `ext_trig` to start a run |
| start | input | 1 | Start pulse |
| stop | input | 1 | Abort pulse |
| ext_tick | input | 1 | External update pulse |
| ext_trig | input | 1 | External start pulse |
| fifo_clear | input | 1 | Empty the playback buffer while idle |
| push_valid | input | 1 | Push word valid |
| push_ready | output | 1 | Buffer can accept a word |
| push_data | input | W | Word to push |
| pat_out | output | W | Pattern output |
| busy | output | 1 | Run active |
| done | output | 1 | Last run finished its programmed cycles |

## Verification
A wrong phase or hold count in the engine is invisible until the output reaches a turning point. It then shows on `pat_out` at the next update tick, as a wrong step direction or a top held for the wrong length. A divider fault shifts the first change of `pat_out` away from `cfg_div`+1 clocks after the start edge, so it appears within one update period. A cycle-counter fault shows as `busy` falling and `done` rising one shape cycle early or late. A wrong buffer pointer shows as a word out of order on the first update after it. A behavioural model in the bench follows every edge, so any of these faults shows as a mismatch on the same clock.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [2:0] {
    PG_FIFO   = 3'd0,
    PG_RISE   = 3'd1,
    PG_FALL   = 3'd2,
    PG_PYR    = 3'd3,
    PG_INVPYR = 3'd4,
    PG_SQUARE = 3'd5,
    PG_TRAP   = 3'd6,
    PG_SHIFT  = 3'd7
  } pg_kind_e;

  typedef enum logic [1:0] {
    PH_UP   = 2'd0,
    PH_DOWN = 2'd1,
    PH_HOLD = 2'd2
  } pg_phase_e;
endpackage

// File: rtl/pg_tick.sv
module pg_tick #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  input  logic            ext_sel,
  input  logic            ext_tick,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q;
  logic            wrap;

  assign wrap = (cnt_q == div);
  assign tick = run && (ext_sel ? ext_tick : wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + DIVW'(1);
  end
endmodule

// File: rtl/pg_fifo.sv
module pg_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          clear,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [AW:0]   count
);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  cnt_q;
  logic         fire;
  logic         wipe;

  assign wipe     = clear && !lock;
  assign in_ready = !lock && (cnt_q < FULL);
  assign fire     = in_valid && in_ready && !wipe;
  assign rd_data  = mem[rd_addr];
  assign count    = cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (fire && (cnt_q == (AW+1)'(i))) mem[i] <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wipe)  cnt_q <= '0;
    else if (fire)  cnt_q <= cnt_q + (AW+1)'(1);
  end
endmodule

// File: rtl/pg_shape.sv
module pg_shape
  import pg_pkg::*;
#(
  parameter int W    = 32,
  parameter int CNTW = 16,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            adv,
  input  logic [2:0]      kind_i,
  input  logic [W-1:0]    start_v,
  input  logic [W-1:0]    stop_v,
  input  logic [W-1:0]    slope,
  input  logic [CNTW-1:0] hold,
  input  logic            clip,
  input  logic [AW:0]     fifo_cnt,
  input  logic [W-1:0]    fifo_rdata,
  output logic [AW-1:0]   rd_addr,
  output logic [W-1:0]    value,
  output logic            cyc_end
);
  pg_kind_e        kind;
  pg_phase_e       ph_q, ph_n;
  logic [W-1:0]    val_q, val_n;
  logic [CNTW-1:0] hc_q, hc_n;
  logic [AW-1:0]   rd_q, rd_n;
  logic [W-1:0]    lo, hi;
  logic            at_hi, at_lo, inverted, last_word;

  function automatic logic [W-1:0] step_up(input logic [W-1:0] v, input logic [W-1:0] lim,
                                           input logic [W-1:0] st, input logic cl);
    logic [W:0] s;
    s = {1'b0, v} + {1'b0, st};
    if (cl && (s >= {1'b0, lim})) return lim;
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] step_dn(input logic [W-1:0] v, input logic [W-1:0] lim,
                                           input logic [W-1:0] st, input logic cl);
    logic [W:0] d;
    d = {1'b0, v} - {1'b0, st};
    if (cl && (d[W] || (d[W-1:0] <= lim))) return lim;
    return d[W-1:0];
  endfunction

  assign kind      = pg_kind_e'(kind_i);
  assign inverted  = (kind == PG_FALL) || (kind == PG_INVPYR);
  assign lo        = inverted ? stop_v : start_v;
  assign hi        = inverted ? start_v : stop_v;
  assign at_hi     = (val_q >= hi);
  assign at_lo     = (val_q <= lo);
  assign last_word = ({1'b0, rd_q} == (fifo_cnt - (AW+1)'(1)));
  assign rd_addr   = load ? '0 : rd_n;
  assign value     = val_q;

  always_comb begin
    val_n   = val_q;
    ph_n    = ph_q;
    hc_n    = hc_q;
    rd_n    = rd_q;
    cyc_end = 1'b0;
    unique case (kind)
      PG_FIFO: begin
        cyc_end = last_word;
        rd_n    = last_word ? '0 : rd_q + AW'(1);
        val_n   = fifo_rdata;
      end
      PG_RISE: begin
        if (at_hi) begin cyc_end = 1'b1; val_n = lo; end
        else val_n = step_up(val_q, hi, slope, clip);
      end
      PG_FALL: begin
        if (at_lo) begin cyc_end = 1'b1; val_n = hi; end
        else val_n = step_dn(val_q, lo, slope, clip);
      end
      PG_PYR: begin
        if (ph_q == PH_UP) begin
          if (at_hi) begin ph_n = PH_DOWN; val_n = step_dn(val_q, lo, slope, clip); end
          else val_n = step_up(val_q, hi, slope, clip);
        end else begin
          if (at_lo) begin
            cyc_end = 1'b1; ph_n = PH_UP; val_n = step_up(val_q, hi, slope, clip);
          end else val_n = step_dn(val_q, lo, slope, clip);
        end
      end
      PG_INVPYR: begin
        if (ph_q == PH_DOWN) begin
          if (at_lo) begin ph_n = PH_UP; val_n = step_up(val_q, hi, slope, clip); end
          else val_n = step_dn(val_q, lo, slope, clip);
        end else begin
          if (at_hi) begin
            cyc_end = 1'b1; ph_n = PH_DOWN; val_n = step_dn(val_q, lo, slope, clip);
          end else val_n = step_up(val_q, hi, slope, clip);
        end
      end
      PG_SQUARE: begin
        if (ph_q == PH_UP) begin ph_n = PH_DOWN; val_n = stop_v; end
        else begin cyc_end = 1'b1; ph_n = PH_UP; val_n = start_v; end
      end
      PG_TRAP: begin
        unique case (ph_q)
          PH_UP: begin
            if (at_hi) begin
              if (hold == '0) begin ph_n = PH_DOWN; val_n = step_dn(val_q, lo, slope, clip); end
              else begin ph_n = PH_HOLD; hc_n = CNTW'(1); end
            end else val_n = step_up(val_q, hi, slope, clip);
          end
          PH_HOLD: begin
            if (hc_q >= hold) begin ph_n = PH_DOWN; val_n = step_dn(val_q, lo, slope, clip); end
            else hc_n = hc_q + CNTW'(1);
          end
          default: begin
            if (at_lo) begin
              cyc_end = 1'b1; ph_n = PH_UP; val_n = step_up(val_q, hi, slope, clip);
            end else val_n = step_dn(val_q, lo, slope, clip);
          end
        endcase
      end
      PG_SHIFT: begin
        if ((val_q == stop_v) || (val_q == '0)) begin cyc_end = 1'b1; val_n = start_v; end
        else val_n = val_q << 1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      ph_q  <= PH_UP;
      hc_q  <= '0;
      rd_q  <= '0;
    end else if (load) begin
      val_q <= (kind == PG_FIFO) ? fifo_rdata : start_v;
      ph_q  <= inverted ? PH_DOWN : PH_UP;
      hc_q  <= '0;
      rd_q  <= '0;
    end else if (adv) begin
      val_q <= val_n;
      ph_q  <= ph_n;
      hc_q  <= hc_n;
      rd_q  <= rd_n;
    end
  end
endmodule

// File: rtl/pattern_gen.sv
module pattern_gen
  import pg_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int DIVW  = 16,
  parameter int CNTW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cfg_type,
  input  logic [W-1:0]    cfg_start,
  input  logic [W-1:0]    cfg_stop,
  input  logic [W-1:0]    cfg_slope,
  input  logic [CNTW-1:0] cfg_hold,
  input  logic [CNTW-1:0] cfg_cycles,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            cfg_clip,
  input  logic            cfg_tick_ext,
  input  logic            cfg_trig_ext,
  input  logic            start,
  input  logic            stop,
  input  logic            ext_tick,
  input  logic            ext_trig,
  input  logic            fifo_clear,
  input  logic            push_valid,
  output logic            push_ready,
  input  logic [W-1:0]    push_data,
  output logic [W-1:0]    pat_out,
  output logic            busy,
  output logic            done
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic            busy_q, done_q;
  logic [CNTW-1:0] ccnt_q;
  logic            go_w, tick_w, cyc_end, finish, adv;
  logic [AW:0]     fifo_cnt;
  logic [AW-1:0]   rd_addr;
  logic [W-1:0]    rd_data;
  logic            fifo_empty_block, counted;

  assign fifo_empty_block = (pg_kind_e'(cfg_type) == PG_FIFO) && (fifo_cnt == '0);
  assign go_w    = !busy_q && (start || (cfg_trig_ext && ext_trig)) && !fifo_empty_block;
  assign counted = (cfg_cycles != '0);
  assign finish  = tick_w && cyc_end && counted && ((ccnt_q + CNTW'(1)) == cfg_cycles);
  assign adv     = tick_w && !stop && !finish;

  pg_tick #(.DIVW(DIVW)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .div      (cfg_div),
    .ext_sel  (cfg_tick_ext),
    .ext_tick (ext_tick),
    .tick     (tick_w)
  );

  pg_fifo #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock     (busy_q),
    .clear    (fifo_clear),
    .in_valid (push_valid),
    .in_ready (push_ready),
    .in_data  (push_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .count    (fifo_cnt)
  );

  pg_shape #(.W(W), .CNTW(CNTW), .AW(AW)) u_shape (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (go_w),
    .adv        (adv),
    .kind_i     (cfg_type),
    .start_v    (cfg_start),
    .stop_v     (cfg_stop),
    .slope      (cfg_slope),
    .hold       (cfg_hold),
    .clip       (cfg_clip),
    .fifo_cnt   (fifo_cnt),
    .fifo_rdata (rd_data),
    .rd_addr    (rd_addr),
    .value      (pat_out),
    .cyc_end    (cyc_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ccnt_q <= '0;
    end else if (go_w) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      ccnt_q <= '0;
    end else if (busy_q) begin
      if (stop) busy_q <= 1'b0;
      else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (tick_w && cyc_end && counted) begin
        ccnt_q <= ccnt_q + CNTW'(1);
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         stop,
  input logic         push_ready,
  input logic [W-1:0] pat_out,
  input logic         tick_w,
  input logic         go_w,
  input logic [AW:0]  fifo_cnt
);
  a_r11_done_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r3_busy_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !push_ready);

  a_r3_full_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == (AW+1)'(DEPTH)) |-> !push_ready);

  a_r2_steady_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_w) |=> $stable(pat_out));

  a_r12_stop_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop) |=> (!busy && !done));

  a_r11_done_holds_output: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go_w) |=> (done && $stable(pat_out)));
endmodule

bind pattern_gen pg_checker #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .stop       (stop),
  .push_ready (push_ready),
  .pat_out    (pat_out),
  .tick_w     (tick_w),
  .go_w       (go_w),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/sim_pattern_gen.sv
module sim_pattern_gen;
  localparam int W = 32, DEPTH = 16, DIVW = 16, CNTW = 16;
  localparam longint MSK = 64'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_type = '0;
  logic [W-1:0] cfg_start = '0, cfg_stop = '0, cfg_slope = '0, push_data = '0;
  logic [CNTW-1:0] cfg_hold = '0, cfg_cycles = '0;
  logic [DIVW-1:0] cfg_div = '0;
  logic cfg_clip = 0, cfg_tick_ext = 0, cfg_trig_ext = 0;
  logic start = 0, stop = 0, ext_tick = 0, ext_trig = 0, fifo_clear = 0, push_valid = 0;
  logic push_ready, busy, done;
  logic [W-1:0] pat_out;

  always #2 clk = ~clk;

  pattern_gen #(.W(W), .DEPTH(DEPTH), .DIVW(DIVW), .CNTW(CNTW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_type(cfg_type), .cfg_start(cfg_start), .cfg_stop(cfg_stop),
    .cfg_slope(cfg_slope), .cfg_hold(cfg_hold), .cfg_cycles(cfg_cycles), .cfg_div(cfg_div),
    .cfg_clip(cfg_clip), .cfg_tick_ext(cfg_tick_ext), .cfg_trig_ext(cfg_trig_ext),
    .start(start), .stop(stop), .ext_tick(ext_tick), .ext_trig(ext_trig),
    .fifo_clear(fifo_clear), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .pat_out(pat_out), .busy(busy), .done(done));

  int checks = 0, fails = 0, ncyc = 0;
  string cur = "R1";

  // behavioural reference
  longint fq[$];
  longint m_out = 0;
  bit m_busy = 0, m_done = 0;
  int m_ph = 0, m_hc = 0, m_rd = 0, m_cc = 0, m_tc = 0;

  function automatic longint up_s(longint v, longint lim);
    longint s = v + longint'(cfg_slope);
    if (cfg_clip && s >= lim) return lim;
    return s & MSK;
  endfunction

  function automatic longint dn_s(longint v, longint lim);
    longint d = v - longint'(cfg_slope);
    if (cfg_clip && (d < 0 || d <= lim)) return lim;
    return d & MSK;
  endfunction

  task automatic m_next(output longint nv, output int nph, output int nhc, output int nrd,
                        output bit ce);
    longint lo, hi;
    bit inv = (cfg_type == 2) || (cfg_type == 4);
    lo = inv ? longint'(cfg_stop) : longint'(cfg_start);
    hi = inv ? longint'(cfg_start) : longint'(cfg_stop);
    nv = m_out; nph = m_ph; nhc = m_hc; nrd = m_rd; ce = 0;
    case (cfg_type)
      0: begin
        ce = (m_rd == fq.size() - 1);
        nrd = ce ? 0 : m_rd + 1;
        nv = fq[nrd];
      end
      1: if (m_out >= hi) begin ce = 1; nv = lo; end else nv = up_s(m_out, hi);
      2: if (m_out <= lo) begin ce = 1; nv = hi; end else nv = dn_s(m_out, lo);
      3: if (m_ph == 0) begin
           if (m_out >= hi) begin nph = 1; nv = dn_s(m_out, lo); end else nv = up_s(m_out, hi);
         end else begin
           if (m_out <= lo) begin ce = 1; nph = 0; nv = up_s(m_out, hi); end
           else nv = dn_s(m_out, lo);
         end
      4: if (m_ph == 1) begin
           if (m_out <= lo) begin nph = 0; nv = up_s(m_out, hi); end else nv = dn_s(m_out, lo);
         end else begin
           if (m_out >= hi) begin ce = 1; nph = 1; nv = dn_s(m_out, lo); end
           else nv = up_s(m_out, hi);
         end
      5: if (m_ph == 0) begin nph = 1; nv = cfg_stop; end
         else begin ce = 1; nph = 0; nv = cfg_start; end
      6: if (m_ph == 0) begin
           if (m_out >= hi) begin
             if (cfg_hold == 0) begin nph = 1; nv = dn_s(m_out, lo); end
             else begin nph = 2; nhc = 1; end
           end else nv = up_s(m_out, hi);
         end else if (m_ph == 2) begin
           if (m_hc >= int'(cfg_hold)) begin nph = 1; nv = dn_s(m_out, lo); end
           else nhc = m_hc + 1;
         end else begin
           if (m_out <= lo) begin ce = 1; nph = 0; nv = up_s(m_out, hi); end
           else nv = dn_s(m_out, lo);
         end
      default: if (m_out == longint'(cfg_stop) || m_out == 0) begin ce = 1; nv = cfg_start; end
               else nv = (m_out << 1) & MSK;
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fq.delete(); m_out = 0; m_busy = 0; m_done = 0;
      m_ph = 0; m_hc = 0; m_rd = 0; m_cc = 0; m_tc = 0;
    end else begin
      bit tk, go, ce;
      longint nv; int nph, nhc, nrd, ntc;
      tk = m_busy && (cfg_tick_ext ? ext_tick : (m_tc == int'(cfg_div)));
      go = !m_busy && (start || (cfg_trig_ext && ext_trig)) && !(cfg_type == 0 && fq.size() == 0);
      ntc = !m_busy ? 0 : ((m_tc == int'(cfg_div)) ? 0 : m_tc + 1);
      if (go) begin
        m_busy = 1; m_done = 0; m_cc = 0; m_hc = 0; m_rd = 0;
        m_out = (cfg_type == 0) ? fq[0] : longint'(cfg_start);
        m_ph = (cfg_type == 2 || cfg_type == 4) ? 1 : 0;
      end else if (m_busy) begin
        if (stop) m_busy = 0;
        else if (tk) begin
          m_next(nv, nph, nhc, nrd, ce);
          if (ce && cfg_cycles != 0 && m_cc + 1 == int'(cfg_cycles)) begin
            m_busy = 0; m_done = 1;
          end else begin
            m_out = nv; m_ph = nph; m_hc = nhc; m_rd = nrd;
            if (ce && cfg_cycles != 0) m_cc++;
          end
        end
      end
      if (!m_busy || go) begin end
      if (!(m_busy && !go) || go) begin end
      m_tc = ntc;
    end
  end

  // FIFO side of the model, judged on the state before this edge
  bit pre_busy;
  always @(negedge clk) pre_busy = m_busy;
  always @(posedge clk) begin
    if (rst_n && !pre_busy) begin
      if (fifo_clear) fq.delete();
      else if (push_valid && fq.size() < DEPTH) fq.push_back(longint'(push_data));
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    bit exp_rdy;
    ncyc++;
    exp_rdy = !m_busy && (fq.size() < DEPTH);
    checks++;
    if (longint'(pat_out) != m_out || busy !== m_busy || done !== m_done || push_ready !== exp_rdy) begin
      fails++;
      $display("FAIL %s: out=%h/%h busy=%b/%b done=%b/%b ready=%b/%b (actual/expected)",
               cur, pat_out, m_out[31:0], busy, m_busy, done, m_done, push_ready, exp_rdy);
    end
    if (ncyc > 190000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", ncyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_word(longint d);
    @(negedge clk); push_valid = 1; push_data = d[31:0];
    @(negedge clk); push_valid = 0;
  endtask

  task automatic wait_idle(int maxc);
    for (int i = 0; i < maxc && busy; i++) @(negedge clk);
  endtask

  task automatic launch(int t, longint s, longint e, longint sl, int hd, int cy, bit cl, int dv);
    @(negedge clk);
    cfg_type = t[2:0]; cfg_start = s[31:0]; cfg_stop = e[31:0]; cfg_slope = sl[31:0];
    cfg_hold = hd[15:0]; cfg_cycles = cy[15:0]; cfg_clip = cl; cfg_div = dv[15:0];
    start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run(int t, longint s, longint e, longint sl, int hd, int cy, bit cl, int dv);
    launch(t, s, e, sl, hd, cy, cl, dv);
    wait_idle(5000);
    cyc(4);
  endtask

  initial begin
    cyc(5);
    chk(pat_out == 0 && !busy && !done && push_ready, "R1", {pat_out, busy, done}, 0);
    rst_n = 1;
    cyc(3);
    chk(pat_out == 0 && !busy && push_ready, "R1", pat_out, 0);

    cur = "R3";
    for (int i = 0; i < DEPTH + 1; i++) push_word(64'h1111 * i + 7);
    cyc(1);
    chk(push_ready == 0, "R3", push_ready, 0);

    cur = "R4";
    run(0, 0, 0, 0, 0, 2, 0, 1);
    chk(done == 1, "R4", done, 1);
    cur = "R3";
    launch(0, 0, 0, 0, 0, 1, 0, 2);
    @(negedge clk); fifo_clear = 1; @(negedge clk); fifo_clear = 0;
    push_word(64'hDEAD);
    wait_idle(5000); cyc(3);

    cur = "R4";
    @(negedge clk); fifo_clear = 1; @(negedge clk); fifo_clear = 0;
    launch(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(2);
    chk(busy == 0, "R4", busy, 0);
    push_word(64'hA5); push_word(64'h5A); push_word(64'hFF00FF);
    run(0, 0, 0, 0, 0, 3, 0, 0);

    cur = "R5";
    run(1, 10, 50, 10, 0, 2, 1, 0);
    run(2, 100, 40, 20, 0, 2, 1, 1);
    cur = "R2";
    run(1, 0, 9, 3, 0, 1, 1, 5);
    cur = "R6";
    run(1, 0, 25, 10, 0, 2, 1, 0);
    run(1, 0, 25, 10, 0, 2, 0, 0);
    run(2, 100, 35, 30, 0, 2, 1, 0);
    run(2, 100, 35, 30, 0, 2, 0, 0);
    cur = "R7";
    run(3, 5, 20, 5, 0, 2, 1, 1);
    run(3, 5, 20, 7, 0, 2, 0, 0);
    run(4, 40, 10, 10, 0, 2, 1, 0);
    cur = "R8";
    run(6, 0, 30, 10, 3, 2, 1, 2);
    run(6, 0, 30, 10, 0, 1, 1, 0);
    cur = "R9";
    run(5, 0, 64'hFFFF_FFFF, 0, 0, 3, 0, 1);
    cur = "R10";
    run(7, 1, 64'h100, 0, 0, 2, 0, 0);
    run(7, 3, 5, 0, 0, 1, 0, 0);

    cur = "R11";
    launch(1, 0, 40, 8, 0, 0, 1, 0);
    cyc(80);
    chk(busy == 1, "R11", busy, 1);
    cur = "R12";
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
    cyc(2);
    chk(busy == 0 && done == 0, "R12", {busy, done}, 0);
    cur = "R11";
    run(1, 0, 20, 10, 0, 1, 1, 0);
    cyc(10);
    chk(done == 1, "R11", done, 1);

    cur = "R12";
    @(negedge clk); cfg_trig_ext = 1; cfg_type = 5; cfg_start = 0; cfg_stop = 32'hF0F0_F0F0;
    cfg_cycles = 2; cfg_div = 0;
    ext_trig = 1; @(negedge clk); ext_trig = 0;
    chk(busy == 1, "R12", busy, 1);
    wait_idle(200); cyc(2);
    cfg_trig_ext = 0;
    cur = "R2";
    cfg_tick_ext = 1;
    launch(1, 0, 30, 10, 0, 1, 1, 7);
    repeat (20) begin
      @(negedge clk); ext_tick = 1; @(negedge clk); ext_tick = 0; @(negedge clk);
    end
    wait_idle(100);
    cfg_tick_ext = 0;
    cyc(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule